// File: doc/BRIEF.md
# Legacy Region Page Decoder

This block turns a 32-bit CPU or DMA address into a one-hot target select and a target-local byte offset. It works on 4 KB pages. In the first megabyte it steers each page to main RAM, a backing RAM for the legacy window, the graphics plane, text RAM, the font/sprite pattern area, the character-generator ROM, a small I/O register window, dictionary ROM or system ROM. Above the first megabyte it recognises extended RAM, whose size is given at run time, and a system ROM image at the top of the address space. Everything else is reported as a miss.

Two mode bits change the routing of the legacy window at run time. When main-memory-enable is set, the whole window from 0xC0000 to 0xCFFFF falls back to backing RAM. When it is clear, the pages go to their video, font and I/O targets. Character-ROM-enable further gates one page. Before decoding, the address is aligned to the access size, and DMA addresses are cut down to 24 bits.

The decode is combinational and is followed by one register stage. A request presented at one clock edge is answered after that edge, and a new request can be accepted on every cycle.

Top module: `lpd_page_decoder`

## Requirements
- R1: `req_size` encodes 2'b00 byte, 2'b01 halfword, 2'b10 or 2'b11 word. A halfword clears address bit 0 and a word clears bits 1:0 before decoding, and the offset reflects the aligned address.
- R2: When `req_dma` is 1, the address is ANDed with DMA_MASK (default 0x00FFFFFF) before decoding.
- R3: Addresses 0x00000–0xBFFFF select main RAM (`tgt_sel` bit 0), with offset equal to address bits 19:0.
- R4: Pages 0xC0–0xC7 select the graphics plane (bit 2, offset = address bits 14:0) when main-memory-enable is 0. Otherwise they select backing RAM (bit 1, offset = address bits 15:0).
- R5: Pages 0xC8–0xC9 select text RAM (bit 3, offset = address bits 11:0) when main-memory-enable is 0 and address bit 12 is 0. Otherwise they select backing RAM with offset = address bits 15:0.
- R6: Page 0xCA selects the font/sprite pattern area (bit 4, offset = address bits 11:0) when main-memory-enable is 0. Otherwise it selects backing RAM.
- R7: Page 0xCB selects the character-generator ROM (bit 5, offset = address bits 11:0) only when main-memory-enable is 0 and character-ROM-enable is 1. Otherwise it selects backing RAM.
- R8: Addresses 0xCFF80–0xCFFFF select the I/O window (bit 6, offset = address bits 6:0) when main-memory-enable is 0. The rest of pages 0xCC–0xCF, and all of them when main-memory-enable is 1, select backing RAM.
- R9: Pages 0xD0–0xEF select dictionary ROM (bit 7, offset = address − 0xD0000). Pages 0xF0–0xFF select system ROM (bit 8, offset = 0x30000 + address bits 15:0). Pages 0xFFFC0–0xFFFFF select system ROM with offset = address bits 17:0.
- R10: Addresses from 0x100000 up to, but not including, 0x100000 + `ext_mb`×1 MB select extended RAM (bit 9, offset = address − 0x100000).
- R11: Any other address asserts `tgt_miss`, with `tgt_sel` = 0 and offset 0. `ones_fill` is 1 exactly when a miss is a read (`req_write` = 0), which tells the read path to return all ones.
- R12: Outputs appear one cycle after a request is sampled, and a request is accepted every cycle. With `out_valid` = 1, exactly one of `tgt_sel`/`tgt_miss` is set. With `out_valid` = 0, and after reset, all are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size code |
| req_dma | input | 1 | Request comes from DMA |
| req_write | input | 1 | Request is a write |
| main_mem_en | input | 1 | Legacy window falls back to backing RAM |
| char_rom_en | input | 1 | Character-generator ROM page enabled |
| ext_mb | input | EXT_MB_W | Extended RAM size in MB |
| out_valid | output | 1 | Registered result valid |
| tgt_sel | output | 10 | One-hot target select |
| tgt_offset | output | 32 | Target-local byte offset |
| tgt_miss | output | 1 | Address hits no target |
| ones_fill | output | 1 | Read miss: return all ones |

## Verification
The bench goes after the edges of each region:
- the last main RAM byte, 0xBFFFF;
- the first and last bytes of extended RAM, and the byte just past them;
- the I/O window boundary at 0xCFF7F/0xCFF80;
- the two ends of the high system ROM.

An off-by-one limit compare would either hand the byte past extended RAM to a memory or lose the last byte. A window boundary off by one byte would send the last backing RAM byte to I/O.

Each mode-gated page is tried under all relevant combinations of the two mode bits. Swapping the mode condition or ignoring character-ROM-enable would route to the wrong one-hot bit.

Alignment is tried for every size code. A DMA address with high junk bits must decode like its low 24 bits, while the same address from the CPU must miss.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
    localparam int NUM_TGT = 10;

    typedef enum logic [3:0] {
        T_MAIN   = 4'd0,
        T_BACK   = 4'd1,
        T_GFX    = 4'd2,
        T_TEXT   = 4'd3,
        T_FONT   = 4'd4,
        T_CGROM  = 4'd5,
        T_IO     = 4'd6,
        T_DICT   = 4'd7,
        T_SYSROM = 4'd8,
        T_EXT    = 4'd9,
        T_NONE   = 4'd15
    } tgt_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRD2 = 2'b11
    } size_e;
endpackage

// File: rtl/lpd_addr_norm.sv
module lpd_addr_norm #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] DMA_MASK = 32'h00FF_FFFF
) (
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic [1:0]        size,
    input  logic              dma,
    output logic [ADDR_W-1:0] norm_addr
);
    logic [ADDR_W-1:0] masked;

    always_comb begin
        masked = dma ? (raw_addr & DMA_MASK[ADDR_W-1:0]) : raw_addr;
        norm_addr = masked;
        unique case (size)
            2'b00: norm_addr = masked;
            2'b01: norm_addr[0] = 1'b0;
            default: norm_addr[1:0] = 2'b00;
        endcase
    end
endmodule

// File: rtl/lpd_region_map.sv
module lpd_region_map
    import lpd_pkg::*;
#(
    parameter int EXT_MB_W = 7
) (
    input  logic [31:0]         addr,
    input  logic                mm_en,
    input  logic                cg_en,
    input  logic [EXT_MB_W-1:0] ext_mb,
    output logic [NUM_TGT-1:0]  sel,
    output logic [31:0]         offset,
    output logic                miss
);
    localparam logic [32:0] EXT_BASE = 33'h0_0010_0000;

    logic [19:0] page;
    logic [32:0] ext_limit;
    tgt_e        tgt;

    assign page      = addr[31:12];
    assign ext_limit = EXT_BASE + ({{(33-EXT_MB_W){1'b0}}, ext_mb} << 20);

    always_comb begin
        tgt    = T_NONE;
        offset = '0;
        if (page < 20'h000C0) begin
            tgt    = T_MAIN;
            offset = {12'h0, addr[19:0]};
        end else if (page < 20'h000C8) begin
            tgt    = mm_en ? T_BACK : T_GFX;
            offset = mm_en ? {16'h0, addr[15:0]} : {17'h0, addr[14:0]};
        end else if (page < 20'h000CA) begin
            if (!mm_en && !addr[12]) begin
                tgt    = T_TEXT;
                offset = {20'h0, addr[11:0]};
            end else begin
                tgt    = T_BACK;
                offset = {16'h0, addr[15:0]};
            end
        end else if (page == 20'h000CA) begin
            tgt    = mm_en ? T_BACK : T_FONT;
            offset = mm_en ? {16'h0, addr[15:0]} : {20'h0, addr[11:0]};
        end else if (page == 20'h000CB) begin
            if (!mm_en && cg_en) begin
                tgt    = T_CGROM;
                offset = {20'h0, addr[11:0]};
            end else begin
                tgt    = T_BACK;
                offset = {16'h0, addr[15:0]};
            end
        end else if (page < 20'h000D0) begin
            if (!mm_en && page == 20'h000CF && addr[11:7] == 5'h1F) begin
                tgt    = T_IO;
                offset = {25'h0, addr[6:0]};
            end else begin
                tgt    = T_BACK;
                offset = {16'h0, addr[15:0]};
            end
        end else if (page < 20'h000F0) begin
            tgt    = T_DICT;
            offset = {12'h0, addr[19:0] - 20'hD0000};
        end else if (page < 20'h00100) begin
            tgt    = T_SYSROM;
            offset = {14'h0, 2'b11, addr[15:0]};
        end else if ({1'b0, addr} < ext_limit) begin
            tgt    = T_EXT;
            offset = addr - 32'h0010_0000;
        end else if (page >= 20'hFFFC0) begin
            tgt    = T_SYSROM;
            offset = {14'h0, addr[17:0]};
        end
    end

    for (genvar i = 0; i < NUM_TGT; i++) begin : g_onehot
        assign sel[i] = (tgt == tgt_e'(i));
    end

    assign miss = (tgt == T_NONE);
endmodule

// File: rtl/lpd_page_decoder.sv
module lpd_page_decoder
    import lpd_pkg::*;
#(
    parameter int          EXT_MB_W = 7,
    parameter logic [31:0] DMA_MASK = 32'h00FF_FFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [31:0]         req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_dma,
    input  logic                req_write,
    input  logic                main_mem_en,
    input  logic                char_rom_en,
    input  logic [EXT_MB_W-1:0] ext_mb,
    output logic                out_valid,
    output logic [NUM_TGT-1:0]  tgt_sel,
    output logic [31:0]         tgt_offset,
    output logic                tgt_miss,
    output logic                ones_fill
);
    logic [31:0]        aligned;
    logic [NUM_TGT-1:0] map_sel;
    logic [31:0]        map_off;
    logic               map_miss;

    lpd_addr_norm #(.ADDR_W(32), .DMA_MASK(DMA_MASK)) norm_i (
        .raw_addr  (req_addr),
        .size      (req_size),
        .dma       (req_dma),
        .norm_addr (aligned)
    );

    lpd_region_map #(.EXT_MB_W(EXT_MB_W)) map_i (
        .addr   (aligned),
        .mm_en  (main_mem_en),
        .cg_en  (char_rom_en),
        .ext_mb (ext_mb),
        .sel    (map_sel),
        .offset (map_off),
        .miss   (map_miss)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            tgt_sel    <= '0;
            tgt_offset <= '0;
            tgt_miss   <= 1'b0;
            ones_fill  <= 1'b0;
        end else begin
            out_valid  <= req_valid;
            tgt_sel    <= req_valid ? map_sel : '0;
            tgt_offset <= (req_valid && !map_miss) ? map_off : '0;
            tgt_miss   <= req_valid && map_miss;
            ones_fill  <= req_valid && map_miss && !req_write;
        end
    end
endmodule

// File: rtl/lpd_page_decoder_chk.sv
module lpd_page_decoder_chk
    import lpd_pkg::*;
#(
    parameter int EXT_MB_W = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [31:0]         req_addr,
    input logic [1:0]          req_size,
    input logic                req_dma,
    input logic                req_write,
    input logic                main_mem_en,
    input logic                char_rom_en,
    input logic [EXT_MB_W-1:0] ext_mb,
    input logic                out_valid,
    input logic [NUM_TGT-1:0]  tgt_sel,
    input logic [31:0]         tgt_offset,
    input logic                tgt_miss,
    input logic                ones_fill
);
    a_r12_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({tgt_sel, tgt_miss}) == 1);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (tgt_sel == '0 && !tgt_miss && !ones_fill));

    a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r11_fill_read_miss: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ones_fill == (tgt_miss && !$past(req_write))));

    a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !tgt_miss && $past(req_size[1])) |-> tgt_offset[1:0] == 2'b00);

    a_r3_low_main: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(!req_dma && req_addr[31:20] == 12'h0 && req_addr[19:18] != 2'b11))
        |-> tgt_sel[T_MAIN]);

    a_r2_dma_low_main: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(req_dma && req_addr[23:20] == 4'h0 && req_addr[19:18] != 2'b11))
        |-> tgt_sel[T_MAIN]);
endmodule

bind lpd_page_decoder lpd_page_decoder_chk #(.EXT_MB_W(EXT_MB_W)) chk_i (.*);

// File: tb/lpd_page_decoder_tb_top.sv
`timescale 1ns/1ps
module lpd_page_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = 2'b00;
    logic        req_dma = 1'b0;
    logic        req_write = 1'b0;
    logic        main_mem_en = 1'b0;
    logic        char_rom_en = 1'b0;
    logic [6:0]  ext_mb = 7'd2;
    logic        out_valid;
    logic [9:0]  tgt_sel;
    logic [31:0] tgt_offset;
    logic        tgt_miss;
    logic        ones_fill;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lpd_page_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_dma(req_dma), .req_write(req_write),
        .main_mem_en(main_mem_en), .char_rom_en(char_rom_en), .ext_mb(ext_mb),
        .out_valid(out_valid), .tgt_sel(tgt_sel), .tgt_offset(tgt_offset),
        .tgt_miss(tgt_miss), .ones_fill(ones_fill)
    );

    // exp_tgt < 0 means a miss
    task automatic compare(input string rq, input int exp_tgt, input logic [31:0] exp_off,
                           input logic wr);
        logic [9:0]  es;
        logic [31:0] eo;
        logic        em;
        logic        ef;
        es = (exp_tgt < 0) ? 10'h0 : (10'h1 << exp_tgt);
        em = (exp_tgt < 0);
        eo = em ? 32'h0 : exp_off;
        ef = em && !wr;
        checks++;
        if (!out_valid || tgt_sel !== es || tgt_offset !== eo || tgt_miss !== em || ones_fill !== ef) begin
            failures++;
            $display("FAIL %s: valid=%0b sel=%h off=%h miss=%0b fill=%0b expected valid=1 sel=%h off=%h miss=%0b fill=%0b",
                     rq, out_valid, tgt_sel, tgt_offset, tgt_miss, ones_fill, es, eo, em, ef);
        end
    endtask

    task automatic probe(input string rq, input logic [31:0] a, input logic [1:0] sz,
                         input logic dma, input logic wr, input logic mm, input logic cg,
                         input logic [6:0] ext, input int exp_tgt, input logic [31:0] exp_off);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_dma = dma; req_write = wr;
        main_mem_en = mm; char_rom_en = cg; ext_mb = ext;
        @(negedge clk);
        req_valid = 1'b0;
        compare(rq, exp_tgt, exp_off, wr);
    endtask

    task automatic t_reset();
        checks++;
        if (out_valid !== 1'b0 || tgt_sel !== 10'h0 || tgt_miss !== 1'b0 || ones_fill !== 1'b0) begin
            failures++;
            $display("FAIL R12 reset: valid=%0b sel=%h miss=%0b fill=%0b expected all 0",
                     out_valid, tgt_sel, tgt_miss, ones_fill);
        end
    endtask

    task automatic t_main_r3();
        probe("R3 low", 32'h0001_2345, 2'b00, 0, 0, 0, 0, 7'd2, 0, 32'h12345);
        probe("R3 top", 32'h000B_FFFF, 2'b00, 0, 0, 1, 1, 7'd2, 0, 32'hBFFFF);
    endtask

    task automatic t_align_r1();
        probe("R1 half", 32'h0001_2347, 2'b01, 0, 0, 0, 0, 7'd2, 0, 32'h12346);
        probe("R1 word", 32'h0001_2347, 2'b10, 0, 0, 0, 0, 7'd2, 0, 32'h12344);
        probe("R1 word code 3", 32'h0001_2347, 2'b11, 0, 0, 0, 0, 7'd2, 0, 32'h12344);
    endtask

    task automatic t_gfx_r4();
        probe("R4 plane", 32'h000C_7ABC, 2'b00, 0, 0, 0, 0, 7'd2, 2, 32'h7ABC);
        probe("R4 backing", 32'h000C_7ABC, 2'b00, 0, 0, 1, 0, 7'd2, 1, 32'h7ABC);
    endtask

    task automatic t_text_r5();
        probe("R5 text", 32'h000C_8123, 2'b00, 0, 0, 0, 0, 7'd2, 3, 32'h123);
        probe("R5 bit12 set", 32'h000C_9123, 2'b00, 0, 0, 0, 0, 7'd2, 1, 32'h9123);
        probe("R5 mm backing", 32'h000C_8123, 2'b00, 0, 0, 1, 0, 7'd2, 1, 32'h8123);
    endtask

    task automatic t_font_r6();
        probe("R6 font", 32'h000C_A456, 2'b00, 0, 0, 0, 0, 7'd2, 4, 32'h456);
        probe("R6 backing", 32'h000C_A456, 2'b00, 0, 0, 1, 0, 7'd2, 1, 32'hA456);
    endtask

    task automatic t_cg_r7();
        probe("R7 cg on", 32'h000C_B010, 2'b00, 0, 0, 0, 1, 7'd2, 5, 32'h010);
        probe("R7 cg off", 32'h000C_B010, 2'b00, 0, 0, 0, 0, 7'd2, 1, 32'hB010);
        probe("R7 mm over cg", 32'h000C_B010, 2'b00, 0, 0, 1, 1, 7'd2, 1, 32'hB010);
    endtask

    task automatic t_io_r8();
        probe("R8 io", 32'h000C_FF85, 2'b00, 0, 0, 0, 0, 7'd2, 6, 32'h05);
        probe("R8 below io", 32'h000C_FF7F, 2'b00, 0, 0, 0, 0, 7'd2, 1, 32'hFF7F);
        probe("R8 mm io", 32'h000C_FF85, 2'b00, 0, 0, 1, 0, 7'd2, 1, 32'hFF85);
        probe("R8 first page", 32'h000C_C000, 2'b00, 0, 0, 0, 0, 7'd2, 1, 32'hC000);
    endtask

    task automatic t_rom_r9();
        probe("R9 dict lo", 32'h000D_1234, 2'b00, 0, 0, 0, 0, 7'd2, 7, 32'h01234);
        probe("R9 dict hi", 32'h000E_FFFF, 2'b00, 0, 0, 0, 0, 7'd2, 7, 32'h1FFFF);
        probe("R9 sys low alias", 32'h000F_1234, 2'b00, 0, 0, 0, 0, 7'd2, 8, 32'h31234);
        probe("R9 sys high start", 32'hFFFC_0000, 2'b00, 0, 0, 0, 0, 7'd2, 8, 32'h00000);
        probe("R9 sys high end", 32'hFFFF_FFFF, 2'b10, 0, 0, 0, 0, 7'd2, 8, 32'h3FFFC);
    endtask

    task automatic t_ext_r10();
        probe("R10 first", 32'h0010_0010, 2'b00, 0, 0, 0, 0, 7'd2, 9, 32'h10);
        probe("R10 last", 32'h002F_FFFF, 2'b00, 0, 0, 0, 0, 7'd2, 9, 32'h1FFFFF);
        probe("R10 past end", 32'h0030_0000, 2'b00, 0, 0, 0, 0, 7'd2, -1, 32'h0);
        probe("R10 size zero", 32'h0010_0000, 2'b00, 0, 0, 0, 0, 7'd0, -1, 32'h0);
    endtask

    task automatic t_miss_r11();
        probe("R11 read miss", 32'h8000_0000, 2'b00, 0, 0, 0, 0, 7'd2, -1, 32'h0);
        probe("R11 write miss", 32'h8000_0000, 2'b00, 0, 1, 0, 0, 7'd2, -1, 32'h0);
        probe("R11 below rom", 32'hFFFB_FFFF, 2'b00, 0, 0, 0, 0, 7'd2, -1, 32'h0);
    endtask

    task automatic t_dma_r2();
        probe("R2 dma main", 32'hFF01_2345, 2'b00, 1, 0, 0, 0, 7'd2, 0, 32'h12345);
        probe("R2 cpu same addr", 32'hFF01_2345, 2'b00, 0, 0, 0, 0, 7'd2, -1, 32'h0);
        probe("R2 dma text", 32'hAB0C_8123, 2'b00, 1, 0, 0, 0, 7'd2, 3, 32'h123);
    endtask

    task automatic t_stream_r12();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_0100; req_size = 2'b00; req_dma = 1'b0;
        req_write = 1'b0; main_mem_en = 1'b0; char_rom_en = 1'b0; ext_mb = 7'd2;
        @(negedge clk);
        compare("R12 stream 1", 0, 32'h100, 1'b0);
        req_addr = 32'h000D_0000;
        @(negedge clk);
        compare("R12 stream 2", 7, 32'h0, 1'b0);
        req_addr = 32'h4000_0000;
        @(negedge clk);
        compare("R12 stream 3", -1, 32'h0, 1'b0);
        req_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || tgt_sel !== 10'h0 || tgt_miss !== 1'b0) begin
            failures++;
            $display("FAIL R12 idle: valid=%0b sel=%h miss=%0b expected 0 0 0",
                     out_valid, tgt_sel, tgt_miss);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_main_r3();
        t_align_r1();
        t_gfx_r4();
        t_text_r5();
        t_font_r6();
        t_cg_r7();
        t_io_r8();
        t_rom_r9();
        t_ext_r10();
        t_miss_r11();
        t_dma_r2();
        t_stream_r12();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule